// File: doc/BRIEF.md
# Reloading Timer, Periodic Tick and Watchdog Peripheral

This block sits on a byte-wide CPU register bus and bundles three timing functions. The first is a 16-bit down-counter that reloads itself from a programmed value. Each time it wraps it can raise an interrupt, and its input clock is either the system clock or a slow 32.768 kHz clock enable. The second is a periodic tick generator that divides the slow clock enable by a power of two, chosen from eight rates. The third is a watchdog. Software restarts it by writing to a clear address, and if software stops doing so the watchdog pulses a reset output.

Everything runs in the single system clock domain. The slow clock arrives as the one-cycle enable `slow_ce`. Writes are taken on the rising edge where `bus_we` is high. Read data is a combinational function of `bus_addr`. There are five register offsets:

| Offset | Name | Access | Contents |
|---|---|---|---|
| 0 | control | write | bit 0 selects the timer clock (1 = system clock, 0 = `slow_ce`); bit 2 enables the timer; bit 4 enables its interrupt; bit 7 enables the watchdog |
| 1 | rate | write | bits 7..4 select the tick rate; bits 3..0 are ignored |
| 2 | watchdog clear | write | a write of any data restarts the watchdog |
| 3 | reload low | read and write | bits 7..0 of the reload value |
| 4 | reload high | read and write | bits 15..8 of the reload value |

Control bits 1, 3, 5 and 6 are ignored.

Three state machines do the work:
- Timer machine. `TM_IDLE` goes to `TM_RUN` when the enable bit is set, and `TM_RUN` goes back to `TM_IDLE` when it is cleared. While idle, the counter tracks the reload value.
- Tick machine. `TK_OFF` goes to `TK_RUN` when the top bit of the rate field is set, and `TK_RUN` goes back to `TK_OFF` when it is cleared.
- Watchdog machine. `WD_OFF` goes to `WD_COUNT` when the watchdog is enabled. `WD_COUNT` goes to `WD_BITE` when the count expires, and `WD_BITE` returns to `WD_COUNT` after one cycle. Every state goes to `WD_OFF` when the watchdog is disabled.

Top module: `tmr_wdg_periph`

## Requirements
- R1: After reset, `irq`, `tick_pulse` and `wdg_reset` are low. Both reload bytes read 0, the timer is disabled, the timer interrupt is disabled, the timer clock select is 0, the tick is off and the watchdog is enabled.
- R2: With control bits 0, 2 and 4 set and a reload value N, `irq` pulses once every N+1 system clock cycles.
- R3: With control bit 0 clear, the timer advances only on cycles with `slow_ce` high, so `irq` pulses once every N+1 slow enables.
- R4: `irq` is never high unless the timer enable (control bit 2) and the interrupt enable (control bit 4) were both set in the previous cycle. With bit 4 clear, no interrupt appears.
- R5: Reading offset 3 returns the reload low byte and reading offset 4 returns the reload high byte, as last written. The other offsets read 0.
- R6: A reload write while the timer runs does not disturb the count in progress. The new value sets the period from the next reload on.
- R7: With rate bits 7..4 = 1kkk, `tick_pulse` pulses once every 512·2^kkk enables of `slow_ce`: code 1000 gives 512 and code 1001 gives 1024.
- R8: With rate bit 7 clear, `tick_pulse` stays low.
- R9: When the watchdog is enabled and `slow_ce` is high every cycle, `wdg_reset` goes high exactly WDG_TICKS cycles after the last clear write.
- R10: A clear write restarts the watchdog count: clears spaced closer than WDG_TICKS slow enables keep `wdg_reset` low, and `wdg_reset` is low in the cycle after any clear.
- R11: With control bit 7 clear, `wdg_reset` stays low.
- R12: `wdg_reset` and `tick_pulse` are each high for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_ce | input | 1 | One-cycle enable at the 32.768 kHz rate |
| bus_addr | input | ADDR_W | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Timer interrupt pulse |
| tick_pulse | output | 1 | Periodic tick strobe |
| wdg_reset | output | 1 | Watchdog reset pulse |

## Verification
On every cycle, the assertions check how the outputs are gated by the enables:
- `irq` requires the timer enable and the interrupt enable.
- `tick_pulse` requires the rate field to be on.
- `wdg_reset` requires the watchdog enable.
- `wdg_reset` and `tick_pulse` last one cycle.
- a clear write keeps `wdg_reset` low in the following cycle.

Interval-based behaviour is visible only through the bench's scenarios. This covers the N+1 timer period on each clock source, the power-of-two tick periods, the watchdog timeout measured from a clear, and a reload written mid-run taking effect one period later.

// File: rtl/tmr_wdg_pkg.sv
package tmr_wdg_pkg;

    localparam int OFS_CTRL = 0;
    localparam int OFS_RATE = 1;
    localparam int OFS_WCLR = 2;
    localparam int OFS_RLO  = 3;
    localparam int OFS_RHI  = 4;

    typedef enum logic {TM_IDLE, TM_RUN} tmr_state_e;
    typedef enum logic {TK_OFF, TK_RUN} tick_state_e;
    typedef enum logic [1:0] {WD_OFF, WD_COUNT, WD_BITE} wdg_state_e;

    typedef struct packed {
        logic wdg_en;
        logic irq_en;
        logic tmr_en;
        logic clk_sys;
    } ctrl_t;

endpackage

// File: rtl/tw_regs.sv
module tw_regs
    import tmr_wdg_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int RLD_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output ctrl_t             ctrl,
    output logic [3:0]        rate_sel,
    output logic [RLD_W-1:0]  reload,
    output logic              wdg_clr
);

    logic sel_ctrl, sel_rate, sel_wclr, sel_lo, sel_hi;

    assign sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
    assign sel_rate = (addr == ADDR_W'(OFS_RATE));
    assign sel_wclr = (addr == ADDR_W'(OFS_WCLR));
    assign sel_lo   = (addr == ADDR_W'(OFS_RLO));
    assign sel_hi   = (addr == ADDR_W'(OFS_RHI));

    assign wdg_clr = we && sel_wclr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl     <= '{wdg_en: 1'b1, irq_en: 1'b0, tmr_en: 1'b0, clk_sys: 1'b0};
            rate_sel <= '0;
            reload   <= '0;
        end else if (we) begin
            if (sel_ctrl) begin
                ctrl.clk_sys <= wdata[0];
                ctrl.tmr_en  <= wdata[2];
                ctrl.irq_en  <= wdata[4];
                ctrl.wdg_en  <= wdata[7];
            end
            if (sel_rate) rate_sel     <= wdata[7:4];
            if (sel_lo)   reload[7:0]  <= wdata;
            if (sel_hi)   reload[15:8] <= wdata;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (sel_lo) rdata = reload[7:0];
        if (sel_hi) rdata = reload[15:8];
    end

endmodule

// File: rtl/tw_timer.sv
module tw_timer
    import tmr_wdg_pkg::*;
#(
    parameter int RLD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ie,
    input  logic             clk_sys,
    input  logic             slow_ce,
    input  logic [RLD_W-1:0] reload,
    output logic             irq
);

    tmr_state_e       state_q, state_d;
    logic [RLD_W-1:0] cnt_q;
    logic             ce, wrap;

    assign ce   = clk_sys ? 1'b1 : slow_ce;
    assign wrap = (state_q == TM_RUN) && en && ce && (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TM_IDLE: if (en)  state_d = TM_RUN;
            TM_RUN:  if (!en) state_d = TM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TM_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TM_IDLE)
                cnt_q <= reload;
            else if (ce)
                cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= wrap && ie;
    end

endmodule

// File: rtl/tw_tick.sv
module tw_tick
    import tmr_wdg_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int BASE_LOG2 = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] rate_sel,
    input  logic       slow_ce,
    output logic       tick
);

    tick_state_e      state_q, state_d;
    logic [DIV_W-1:0] cnt_q;
    logic [3:0]       rate_q;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] term;
    logic             fire;

    assign span = (DIV_W+1)'(1) << (BASE_LOG2 + int'(rate_sel[2:0]));
    assign term = DIV_W'(span - (DIV_W+1)'(1));
    assign fire = (state_q == TK_RUN) && rate_sel[3] && (rate_sel == rate_q)
                  && slow_ce && (cnt_q == term);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TK_OFF: if (rate_sel[3])  state_d = TK_RUN;
            TK_RUN: if (!rate_sel[3]) state_d = TK_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TK_OFF;
            cnt_q   <= '0;
            rate_q  <= '0;
        end else begin
            state_q <= state_d;
            rate_q  <= rate_sel;
            if (state_q == TK_OFF || rate_sel != rate_q || fire)
                cnt_q <= '0;
            else if (slow_ce)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= fire;
    end

endmodule

// File: rtl/tw_wdog.sv
module tw_wdog
    import tmr_wdg_pkg::*;
#(
    parameter int WDG_TICKS = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic slow_ce,
    output logic bite
);

    localparam int CW = $clog2(WDG_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(WDG_TICKS - 1);

    wdg_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:   if (en) state_d = WD_COUNT;
            WD_COUNT: if (!en) state_d = WD_OFF;
                      else if (!clr && slow_ce && cnt_q == LAST) state_d = WD_BITE;
            WD_BITE:  state_d = en ? WD_COUNT : WD_OFF;
            default:  state_d = WD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (clr || state_d != WD_COUNT)
                cnt_q <= '0;
            else if (slow_ce && state_q == WD_COUNT)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb bite = (state_q == WD_BITE);

endmodule

// File: rtl/tmr_wdg_periph.sv
module tmr_wdg_periph
    import tmr_wdg_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int WDG_TICKS = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_ce,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic              tick_pulse,
    output logic              wdg_reset
);

    localparam int RLD_W = 16;

    ctrl_t            ctrl_q;
    logic [3:0]       rate_sel;
    logic [RLD_W-1:0] reload;
    logic             wdg_clr;
    logic             tmr_on, tmr_ie, wdg_on, rate_on;

    assign tmr_on  = ctrl_q.tmr_en;
    assign tmr_ie  = ctrl_q.irq_en;
    assign wdg_on  = ctrl_q.wdg_en;
    assign rate_on = rate_sel[3];

    tw_regs #(.ADDR_W(ADDR_W), .RLD_W(RLD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .rdata(bus_rdata), .ctrl(ctrl_q), .rate_sel(rate_sel), .reload(reload),
        .wdg_clr(wdg_clr)
    );

    tw_timer #(.RLD_W(RLD_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(tmr_on), .ie(tmr_ie), .clk_sys(ctrl_q.clk_sys),
        .slow_ce(slow_ce), .reload(reload), .irq(irq)
    );

    tw_tick #(.DIV_W(16), .BASE_LOG2(9)) u_tick (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .slow_ce(slow_ce),
        .tick(tick_pulse)
    );

    tw_wdog #(.WDG_TICKS(WDG_TICKS)) u_wdog (
        .clk(clk), .rst_n(rst_n), .en(wdg_on), .clr(wdg_clr), .slow_ce(slow_ce),
        .bite(wdg_reset)
    );

endmodule

// File: rtl/tmr_wdg_checker.sv
module tmr_wdg_checker (
    input logic clk,
    input logic rst_n,
    input logic irq,
    input logic tick_pulse,
    input logic wdg_reset,
    input logic tmr_on,
    input logic tmr_ie,
    input logic wdg_on,
    input logic rate_on,
    input logic wdg_clr
);

    p_irq_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(tmr_on) && $past(tmr_ie)));

    p_tick_needs_rate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |-> $past(rate_on));

    p_wdg_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_reset |-> $past(wdg_on));

    p_wdg_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_reset |=> !wdg_reset);

    p_tick_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> !tick_pulse);

    p_clear_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_clr |=> !wdg_reset);

endmodule

bind tmr_wdg_periph tmr_wdg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .tick_pulse(tick_pulse),
    .wdg_reset(wdg_reset), .tmr_on(tmr_on), .tmr_ie(tmr_ie), .wdg_on(wdg_on),
    .rate_on(rate_on), .wdg_clr(wdg_clr)
);

// File: tb/tb_tmr_wdg_periph.sv
module tb_tmr_wdg_periph;

    localparam int WDG = 100;
    localparam int NV  = 5;
    // fields: clk_sys[40], slow divider[39:36], reload[35:20], expected period[19:0]
    localparam logic [40:0] TVEC [NV] = '{
        {1'b1, 4'd1, 16'd3,      20'd4},
        {1'b1, 4'd1, 16'd0,      20'd1},
        {1'b1, 4'd1, 16'h0102,   20'd259},
        {1'b0, 4'd4, 16'd2,      20'd12},
        {1'b0, 4'd1, 16'd5,      20'd6}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_ce = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, tick_pulse, wdg_reset;

    int checks = 0;
    int fails = 0;
    int slow_div = 1;
    int slow_cnt = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    tmr_wdg_periph #(.ADDR_W(3), .WDG_TICKS(WDG)) dut (
        .clk(clk), .rst_n(rst_n), .slow_ce(slow_ce), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tick_pulse(tick_pulse), .wdg_reset(wdg_reset)
    );

    always @(negedge clk) begin
        cyc++;
        slow_cnt++;
        if (slow_cnt >= slow_div) begin
            slow_cnt = 0;
            slow_ce  = 1'b1;
        end else begin
            slow_ce = 1'b0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = 3'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_addr = 3'(a);
        #1;
        d = int'(bus_rdata);
    endtask

    // which: 0 irq, 1 tick, 2 watchdog; n = negedges until seen, limit+1 if never
    task automatic wait_for(input int which, input int limit, output int n);
        logic s;
        n = 0;
        while (n < limit) begin
            @(negedge clk);
            n++;
            s = (which == 0) ? irq : (which == 1) ? tick_pulse : wdg_reset;
            if (s) return;
        end
        n = limit + 1;
    endtask

    initial begin : watchdog_timer
        #1_400_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int v, n, p;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 irq", int'(irq), 0);
        chk("R1 tick", int'(tick_pulse), 0);
        chk("R1 wdg", int'(wdg_reset), 0);
        rst_n = 1'b1;
        rd(3, v); chk("R1 reload lo", v, 0);
        rd(4, v); chk("R1 reload hi", v, 0);

        // R9 watchdog enabled at reset, bites WDG cycles after clear
        wr(2, 8'h00);
        wait_for(2, 3 * WDG, n);
        chk("R9 timeout", n, WDG);
        @(negedge clk);
        chk("R12 wdg width", int'(wdg_reset), 0);

        // R10 regular clears keep it quiet
        p = 0;
        for (int i = 0; i < 8; i++) begin
            wr(2, 8'h5A);
            wait_for(2, 60, n);
            if (n <= 60) p++;
        end
        chk("R10 no bite with clears", p, 0);

        // R11 disabled watchdog
        wr(0, 8'h00);
        wr(2, 8'h00);
        wait_for(2, 3 * WDG, n);
        chk("R11 no bite when off", n, 3 * WDG + 1);

        // R2/R3 period table
        for (int i = 0; i < NV; i++) begin
            logic [40:0] e;
            e = TVEC[i];
            slow_div = int'(e[39:36]);
            wr(0, 8'h00);
            wr(3, e[27:20]);
            wr(4, e[35:28]);
            wr(0, {3'b000, 1'b1, 1'b0, 1'b1, 1'b0, e[40]});
            wait_for(0, 3000, n);
            wait_for(0, 3000, p);
            if (e[40]) chk("R2 period sysclk", p, int'(e[19:0]));
            else       chk("R3 period slow", p, int'(e[19:0]));
        end
        slow_div = 1;

        // R4 interrupt masked
        wr(0, 8'h00);
        wr(3, 8'd2);
        wr(4, 8'd0);
        wr(0, 8'h05);
        wait_for(0, 50, n);
        chk("R4 masked irq", n, 51);

        // R5 readback and unused offsets
        wr(0, 8'h00);
        wr(3, 8'hA5);
        wr(4, 8'h3C);
        rd(3, v); chk("R5 lo", v, 8'hA5);
        rd(4, v); chk("R5 hi", v, 8'h3C);
        rd(0, v); chk("R5 ctrl reads 0", v, 0);

        // R6 reload rewritten while running
        wr(3, 8'd3);
        wr(4, 8'd0);
        wr(0, 8'h15);
        wait_for(0, 100, n);
        wait_for(0, 100, p);
        chk("R6 old period", p, 4);
        wr(3, 8'd7);
        wait_for(0, 100, n);
        wait_for(0, 100, p);
        chk("R6 new period", p, 8);
        wr(0, 8'h00);

        // R7 tick rates
        wr(1, 8'h80);
        wait_for(1, 3000, n);
        wait_for(1, 3000, p);
        chk("R7 code 1000", p, 512);
        @(negedge clk);
        chk("R12 tick width", int'(tick_pulse), 0);
        wr(1, 8'h9F);
        wait_for(1, 3000, n);
        wait_for(1, 3000, p);
        chk("R7 code 1001", p, 1024);

        // R8 tick off
        wr(1, 8'h70);
        wait_for(1, 1500, n);
        chk("R8 no tick", n, 1501);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule